// File: doc/BRIEF.md
# NAND Command and Address Sequencer

This block drives the latch-enable, strobe and data pins of a raw NAND flash device for one command cycle or one address phase at a time. A host pulses `start` with a phase kind, a command byte or a flat byte offset, and a geometry setting. For an address phase the offset is split into column bytes and page bytes using the page shift. Each byte is written with a write-enable pulse of programmable low and high width while the proper latch line is held.

After the phase the block waits for the device. With a ready/busy pin it waits for the pin to go high, and a timeout counter raises an error flag if it stays low too long. Without the pin it waits a fixed number of cycles, one count after an address phase and a shorter count after a command. When no ready pin is used and the command was a device reset, it then sends the status command and reads status until the ready bit is set. A one-cycle `done` pulse ends every request.

Top module: `nand_cmdaddr_seq`

## Requirements
- R1: When `phase_kind` is 2'b00, one byte equal to `cmd_byte` is written with `cle` high and `ale` low for the whole strobe, and `cle` is low again before any wait begins.
- R2: For an address phase, `ale` stays high from the first address byte to the end of the last one, with `cle` low. `ale` goes low after the last byte.
- R3: Column bytes are `byte_ofs & (2**cfg_page_shift - 1)`. They are sent least significant byte first, `cfg_col_cycles` bytes (1..2), shifting right 8 bits per byte.
- R4: Page bytes are `byte_ofs >> cfg_page_shift`. They are sent least significant byte first, `cfg_page_cycles` bytes (1..4), shifting right 8 bits per byte.
- R5: `phase_kind` 2'b01 sends column bytes only, 2'b10 sends page bytes only, and 2'b11 sends the column bytes and then the page bytes.
- R6: Every byte is placed on `dq_out[7:0]`, and the upper bus bits are zero. `dq_oe` is high only while a latch line is high, and never while `re_n` is low.
- R7: Each byte gets `we_n` low for exactly WE_LO_CYC cycles and then high for WE_HI_CYC cycles. The next byte of a phase starts at once.
- R8: With `cfg_use_rb` low, the wait lasts ADDR_WAIT_CYC cycles after an address phase and CMD_WAIT_CYC cycles after a command. `done` is high 1 + N*(WE_LO_CYC+WE_HI_CYC) + W cycles after the clock edge that samples `start`, where N is the byte count and W the wait.
- R9: With `cfg_use_rb` low and command byte 8'hFF, the block then writes 8'h70 with `cle` high. It then repeats read strobes on `re_n` (WE_LO_CYC low, WE_HI_CYC high), sampling `dq_in` at the end of each. It stops when bit 6 is set. With `cfg_use_rb` high no status read takes place.
- R10: With `cfg_use_rb` high, `done` follows one cycle after `rb_ready` is seen high in the wait. If `rb_ready` stays low for RB_TMO_CYC wait cycles, `done` is raised together with `timeout_err`. `timeout_err` holds until the next accepted `start`.
- R11: `done` is a single-cycle pulse. A `start` while `busy` is high is ignored and changes neither the bytes sent nor the timing.
- R12: During and after reset all outputs are idle: `cle`, `ale`, `dq_oe`, `busy`, `done` and `timeout_err` low, and `we_n` and `re_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted only when idle |
| phase_kind | input | 2 | 00 command, 01 column, 10 page, 11 column then page |
| cmd_byte | input | 8 | Command byte for a command cycle |
| byte_ofs | input | OFS_W | Flat byte offset for an address phase |
| cfg_page_shift | input | SH_W | Page shift (8, 9 or 11) |
| cfg_col_cycles | input | COLC_W | Number of column bytes |
| cfg_page_cycles | input | PGC_W | Number of page bytes |
| cfg_use_rb | input | 1 | 1: wait on ready/busy pin, 0: fixed delay |
| rb_ready | input | 1 | Device ready/busy, high when ready |
| dq_in | input | DQ_W | Data bus from the device |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| dq_out | output | DQ_W | Data bus to the device |
| dq_oe | output | 1 | Drive enable for `dq_out` |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | Ready/busy wait timed out |

## Verification
The request is accepted at the clock edge that samples `start`. The first strobe begins one cycle later, each byte then takes WE_LO_CYC+WE_HI_CYC cycles, and the wait adds its own count, so `done` is due at a cycle that can be computed from the requirement. The bench counts falling clock edges from the one after `start` and compares the count at which `done` is seen with that formula. It collects each written byte at the falling edge after `we_n` rises, together with the latch lines and the low width. The status-read model in the bench returns ready on its third read, so a reset request has a fixed latency. A ready pin raised at a known cycle must give `done` exactly one cycle later.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [1:0] {
    PH_CMD     = 2'b00,
    PH_COL     = 2'b01,
    PH_PAGE    = 2'b10,
    PH_COLPAGE = 2'b11
  } phase_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_CMD,
    S_ADDR,
    S_WAIT,
    S_POLL_CMD,
    S_POLL_RD,
    S_DONE
  } seq_state_e;

  localparam logic [7:0] OP_RESET  = 8'hFF;
  localparam logic [7:0] OP_STATUS = 8'h70;
  localparam int         RDY_BIT   = 6;

endpackage

// File: rtl/nand_addr_byte.sv
module nand_addr_byte #(
  parameter int OFS_W = 32,
  parameter int SH_W  = 5,
  parameter int IDX_W = 3
) (
  input  logic [OFS_W-1:0] offset,
  input  logic [SH_W-1:0]  shift,
  input  logic [IDX_W-1:0] ncol,
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       byte_o
);

  logic [OFS_W-1:0] col_mask;
  logic [OFS_W-1:0] col_val;
  logic [OFS_W-1:0] page_val;
  logic [OFS_W-1:0] sel_val;
  logic [IDX_W-1:0] page_idx;

  always_comb begin
    col_mask = ~({OFS_W{1'b1}} << shift);
    col_val  = offset & col_mask;
    page_val = offset >> shift;
    page_idx = idx - ncol;
    if (idx < ncol) begin
      sel_val = col_val >> {idx, 3'b000};
    end else begin
      sel_val = page_val >> {page_idx, 3'b000};
    end
    byte_o = sel_val[7:0];
  end

endmodule

// File: rtl/nand_strobe.sv
module nand_strobe #(
  parameter int LO_CYC = 2,
  parameter int HI_CYC = 2,
  localparam int CNT_W = $clog2(LO_CYC + HI_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic active,
  output logic low,
  output logic fin
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(LO_CYC + HI_CYC - 1);
  localparam logic [CNT_W-1:0] LOW_END = CNT_W'(LO_CYC);

  logic             act_q, act_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             en;

  assign fin    = act_q && (cnt_q == LAST);
  assign low    = act_q && (cnt_q < LOW_END);
  assign active = act_q;
  assign en     = go || act_q;

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    if (go) begin
      act_d = 1'b1;
      cnt_d = '0;
    end else if (fin) begin
      act_d = 1'b0;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (en) begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/nand_wait_ctr.sv
module nand_wait_ctr #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr || en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/nand_cmdaddr_seq.sv
module nand_cmdaddr_seq
  import nand_seq_pkg::*;
#(
  parameter int OFS_W         = 32,
  parameter int DQ_W          = 16,
  parameter int MAX_COL       = 2,
  parameter int MAX_PAGE      = 4,
  parameter int WE_LO_CYC     = 2,
  parameter int WE_HI_CYC     = 2,
  parameter int CMD_WAIT_CYC  = 1250,
  parameter int ADDR_WAIT_CYC = 3125,
  parameter int RB_TMO_CYC    = 12500,
  localparam int SH_W   = $clog2(OFS_W),
  localparam int COLC_W = $clog2(MAX_COL + 1),
  localparam int PGC_W  = $clog2(MAX_PAGE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        phase_kind,
  input  logic [7:0]        cmd_byte,
  input  logic [OFS_W-1:0]  byte_ofs,
  input  logic [SH_W-1:0]   cfg_page_shift,
  input  logic [COLC_W-1:0] cfg_col_cycles,
  input  logic [PGC_W-1:0]  cfg_page_cycles,
  input  logic              cfg_use_rb,
  input  logic              rb_ready,
  input  logic [DQ_W-1:0]   dq_in,
  output logic              cle,
  output logic              ale,
  output logic              we_n,
  output logic              re_n,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe,
  output logic              busy,
  output logic              done,
  output logic              timeout_err
);

  localparam int IDX_W  = $clog2(MAX_COL + MAX_PAGE + 1);
  localparam int WMAX_A = (CMD_WAIT_CYC > ADDR_WAIT_CYC) ? CMD_WAIT_CYC : ADDR_WAIT_CYC;
  localparam int WMAX   = (WMAX_A > RB_TMO_CYC) ? WMAX_A : RB_TMO_CYC;
  localparam int WCNT_W = $clog2(WMAX + 1);
  localparam logic [WCNT_W-1:0] CMD_LAST  = WCNT_W'(CMD_WAIT_CYC - 1);
  localparam logic [WCNT_W-1:0] ADDR_LAST = WCNT_W'(ADDR_WAIT_CYC - 1);
  localparam logic [WCNT_W-1:0] TMO_LAST  = WCNT_W'(RB_TMO_CYC - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_ni = rst_sync_q[1];

  // state and request registers
  seq_state_e         st_q, st_d;
  phase_e             kind_q;
  logic [7:0]         cmd_q;
  logic [OFS_W-1:0]   ofs_q;
  logic [SH_W-1:0]    sh_q;
  logic [COLC_W-1:0]  ncol_q;
  logic [PGC_W-1:0]   npage_q;
  logic               userb_q;
  logic [IDX_W-1:0]   bidx_q, bidx_d;
  logic [7:0]         dq_q, dq_d;
  logic               err_q, err_d;
  logic               load_cfg;

  // strobe and wait helpers
  logic               go;
  logic               stb_active;
  logic               stb_low;
  logic               stb_fin;
  logic               wclr;
  logic               wen;
  logic [WCNT_W-1:0]  wcnt;
  logic [WCNT_W-1:0]  wlast;

  // address byte selection
  logic [IDX_W-1:0]   ncol_eff;
  logic [IDX_W-1:0]   npage_eff;
  logic [IDX_W-1:0]   nbytes;
  logic [IDX_W-1:0]   idx_nx;
  logic [7:0]         abyte;
  logic               stat_rdy;
  logic               unused_dq;

  assign ncol_eff  = kind_q[0] ? IDX_W'(ncol_q) : '0;
  assign npage_eff = kind_q[1] ? IDX_W'(npage_q) : '0;
  assign nbytes    = ncol_eff + npage_eff;
  assign idx_nx    = (st_q == S_LOAD) ? '0 : bidx_q + 1'b1;
  assign stat_rdy  = dq_in[RDY_BIT];
  assign unused_dq = ^dq_in;

  nand_addr_byte #(
    .OFS_W (OFS_W),
    .SH_W  (SH_W),
    .IDX_W (IDX_W)
  ) u_abyte (
    .offset (ofs_q),
    .shift  (sh_q),
    .ncol   (ncol_eff),
    .idx    (idx_nx),
    .byte_o (abyte)
  );

  nand_strobe #(
    .LO_CYC (WE_LO_CYC),
    .HI_CYC (WE_HI_CYC)
  ) u_strobe (
    .clk    (clk),
    .rst_n  (rst_ni),
    .go     (go),
    .active (stb_active),
    .low    (stb_low),
    .fin    (stb_fin)
  );

  assign wen = (st_q == S_WAIT);

  nand_wait_ctr #(
    .CNT_W (WCNT_W)
  ) u_wait (
    .clk   (clk),
    .rst_n (rst_ni),
    .clr   (wclr),
    .en    (wen),
    .cnt_o (wcnt)
  );

  always_comb begin
    if (userb_q) begin
      wlast = TMO_LAST;
    end else if (kind_q == PH_CMD) begin
      wlast = CMD_LAST;
    end else begin
      wlast = ADDR_LAST;
    end
  end

  // next-state logic
  always_comb begin
    st_d     = st_q;
    go       = 1'b0;
    load_cfg = 1'b0;
    wclr     = 1'b0;
    dq_d     = dq_q;
    bidx_d   = bidx_q;
    err_d    = err_q;
    unique case (st_q)
      S_IDLE: begin
        if (start) begin
          st_d     = S_LOAD;
          load_cfg = 1'b1;
          err_d    = 1'b0;
        end
      end
      S_LOAD: begin
        go     = 1'b1;
        bidx_d = '0;
        if (kind_q == PH_CMD) begin
          st_d = S_CMD;
          dq_d = cmd_q;
        end else begin
          st_d = S_ADDR;
          dq_d = abyte;
        end
      end
      S_CMD: begin
        if (stb_fin) begin
          st_d = S_WAIT;
          wclr = 1'b1;
        end
      end
      S_ADDR: begin
        if (stb_fin) begin
          if (idx_nx < nbytes) begin
            go     = 1'b1;
            dq_d   = abyte;
            bidx_d = idx_nx;
          end else begin
            st_d = S_WAIT;
            wclr = 1'b1;
          end
        end
      end
      S_WAIT: begin
        if (userb_q) begin
          if (rb_ready) begin
            st_d = S_DONE;
          end else if (wcnt == wlast) begin
            st_d  = S_DONE;
            err_d = 1'b1;
          end
        end else if (wcnt == wlast) begin
          if ((kind_q == PH_CMD) && (cmd_q == OP_RESET)) begin
            st_d = S_POLL_CMD;
            go   = 1'b1;
            dq_d = OP_STATUS;
          end else begin
            st_d = S_DONE;
          end
        end
      end
      S_POLL_CMD: begin
        if (stb_fin) begin
          st_d = S_POLL_RD;
          go   = 1'b1;
        end
      end
      S_POLL_RD: begin
        if (stb_fin) begin
          if (stat_rdy) begin
            st_d = S_DONE;
          end else begin
            go = 1'b1;
          end
        end
      end
      S_DONE: begin
        st_d = S_IDLE;
      end
      default: begin
        st_d = S_IDLE;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      dq_q   <= '0;
      bidx_q <= '0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      dq_q   <= dq_d;
      bidx_q <= bidx_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q  <= PH_CMD;
      cmd_q   <= '0;
      ofs_q   <= '0;
      sh_q    <= '0;
      ncol_q  <= '0;
      npage_q <= '0;
      userb_q <= 1'b0;
    end else if (load_cfg) begin
      kind_q  <= phase_e'(phase_kind);
      cmd_q   <= cmd_byte;
      ofs_q   <= byte_ofs;
      sh_q    <= cfg_page_shift;
      ncol_q  <= cfg_col_cycles;
      npage_q <= cfg_page_cycles;
      userb_q <= cfg_use_rb;
    end
  end

  // pin outputs
  assign cle         = (st_q == S_CMD) || (st_q == S_POLL_CMD);
  assign ale         = (st_q == S_ADDR);
  assign dq_oe       = cle || ale;
  assign we_n        = !(stb_active && stb_low && dq_oe);
  assign re_n        = !(stb_active && stb_low && (st_q == S_POLL_RD));
  assign dq_out      = DQ_W'(dq_q);
  assign busy        = (st_q != S_IDLE);
  assign done        = (st_q == S_DONE);
  assign timeout_err = err_q;

endmodule

// File: rtl/nand_cmdaddr_seq_chk.sv
module nand_cmdaddr_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic cle,
  input logic ale,
  input logic we_n,
  input logic re_n,
  input logic dq_oe,
  input logic busy,
  input logic done,
  input logic timeout_err
);

  // R1 / R2: the two latch lines never overlap
  a_r1_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));

  // R2: ale holds through the low part of every address strobe
  a_r2_ale_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && ale) |=> ale);

  // R6: no bus drive while the device drives status
  a_r6_oe_not_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> !dq_oe);

  // R9: read and write strobes never overlap
  a_r9_rw_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));

  // R10: the error flag rises only with completion
  a_r10_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> done);

  // R10: the error flag clears only on an accepted request
  a_r10_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(timeout_err) |-> busy);

  // R11: done is a single-cycle pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11: a running request is not cut short by a new start
  a_r11_busy_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> busy);

  // R12: idle means quiet pins
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (we_n && re_n && !cle && !ale && !dq_oe));

endmodule

bind nand_cmdaddr_seq nand_cmdaddr_seq_chk chk_i (.*);

// File: tb/nand_cmdaddr_seq_tb.sv
module nand_cmdaddr_seq_tb_top;

  localparam int OFS_W = 32;
  localparam int DQ_W  = 16;
  localparam int LO    = 2;
  localparam int HI    = 1;
  localparam int TB_CW = 6;
  localparam int TB_AW = 15;
  localparam int TB_TO = 40;
  localparam int STB   = LO + HI;

  typedef struct packed {
    logic [1:0]  kind;
    logic [7:0]  cmd;
    logic [31:0] ofs;
    logic [4:0]  sh;
    logic [1:0]  nc;
    logic [2:0]  np;
    logic [2:0]  nb;
    logic [47:0] exp;
  } vec_t;

  // R1 R3 R4 R5 vectors: expected bytes, lowest byte sent first
  localparam vec_t VECS [8] = '{
    '{2'd0, 8'h30, 32'h0000_0000, 5'd9,  2'd1, 3'd1, 3'd1, 48'h0000_0000_0030},
    '{2'd3, 8'h00, 32'h0001_2345, 5'd9,  2'd1, 3'd3, 3'd4, 48'h0000_0000_9145},
    '{2'd3, 8'h00, 32'h0ABC_DEF1, 5'd11, 2'd2, 3'd3, 3'd5, 48'h0001_579B_06F1},
    '{2'd1, 8'h00, 32'h0000_03A7, 5'd8,  2'd1, 3'd2, 3'd1, 48'h0000_0000_00A7},
    '{2'd2, 8'h00, 32'h00FE_DC80, 5'd8,  2'd2, 3'd2, 3'd2, 48'h0000_0000_FEDC},
    '{2'd1, 8'h00, 32'hFFFF_FFFF, 5'd11, 2'd2, 3'd1, 3'd2, 48'h0000_0000_07FF},
    '{2'd3, 8'h00, 32'h89AB_CDEF, 5'd8,  2'd1, 3'd4, 3'd5, 48'h0000_89AB_CDEF},
    '{2'd0, 8'h90, 32'h1234_5678, 5'd11, 2'd2, 3'd4, 3'd1, 48'h0000_0000_0090}
  };

  logic            clk;
  logic            rst_n;
  logic            start;
  logic [1:0]      phase_kind;
  logic [7:0]      cmd_byte;
  logic [OFS_W-1:0] byte_ofs;
  logic [4:0]      cfg_page_shift;
  logic [1:0]      cfg_col_cycles;
  logic [2:0]      cfg_page_cycles;
  logic            cfg_use_rb;
  logic            rb_ready;
  logic [DQ_W-1:0] dq_in;
  logic            cle, ale, we_n, re_n, dq_oe, busy, done, timeout_err;
  logic [DQ_W-1:0] dq_out;

  int n_checks = 0;
  int n_fail   = 0;

  nand_cmdaddr_seq #(
    .OFS_W         (OFS_W),
    .DQ_W          (DQ_W),
    .MAX_COL       (2),
    .MAX_PAGE      (4),
    .WE_LO_CYC     (LO),
    .WE_HI_CYC     (HI),
    .CMD_WAIT_CYC  (TB_CW),
    .ADDR_WAIT_CYC (TB_AW),
    .RB_TMO_CYC    (TB_TO)
  ) dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .start           (start),
    .phase_kind      (phase_kind),
    .cmd_byte        (cmd_byte),
    .byte_ofs        (byte_ofs),
    .cfg_page_shift  (cfg_page_shift),
    .cfg_col_cycles  (cfg_col_cycles),
    .cfg_page_cycles (cfg_page_cycles),
    .cfg_use_rb      (cfg_use_rb),
    .rb_ready        (rb_ready),
    .dq_in           (dq_in),
    .cle             (cle),
    .ale             (ale),
    .we_n            (we_n),
    .re_n            (re_n),
    .dq_out          (dq_out),
    .dq_oe           (dq_oe),
    .busy            (busy),
    .done            (done),
    .timeout_err     (timeout_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // monitor: collect written bytes, strobe widths, reads
  logic [15:0] cap_dq  [8];
  logic        cap_cle [8];
  logic        cap_ale [8];
  int          cap_lo  [8];
  int          cap_n = 0;
  int          lo_run = 0;
  int          hi_run = 0;
  int          gap_last = 0;
  int          rd_cnt = 0;
  int          oe_bad = 0;
  int          ale_gap = 0;
  int          mon_nb = 0;
  logic        mon_addr = 1'b0;
  int          clr_tok = 0;
  int          seen_tok = 0;
  logic        prev_we = 1'b1;
  logic        prev_re = 1'b1;
  logic [15:0] hold_dq;
  logic        hold_cle, hold_ale;

  assign dq_in = (rd_cnt >= 3) ? 16'h00C0 : 16'h0080;

  always @(negedge clk) begin
    if (clr_tok != seen_tok) begin
      cap_n = 0; rd_cnt = 0; oe_bad = 0; ale_gap = 0; gap_last = 0;
      seen_tok = clr_tok;
    end
    if (!we_n) begin
      if (prev_we) begin
        if (cap_n > 0) gap_last = hi_run;
        lo_run = 0;
      end
      lo_run++;
      hold_dq = dq_out; hold_cle = cle; hold_ale = ale;
    end else begin
      if (!prev_we) begin
        if (cap_n < 8) begin
          cap_dq[cap_n] = hold_dq; cap_cle[cap_n] = hold_cle;
          cap_ale[cap_n] = hold_ale; cap_lo[cap_n] = lo_run;
          cap_n++;
        end
        hi_run = 0;
      end
      hi_run++;
    end
    if (!re_n && prev_re) rd_cnt++;
    if (!re_n && dq_oe) oe_bad++;
    if (mon_addr && cap_n >= 1 && cap_n < mon_nb && !ale) ale_gap++;
    prev_we = we_n;
    prev_re = re_n;
  end

  task automatic chk(input logic ok, input string req, input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic issue(input logic [1:0] k, input logic [7:0] c, input logic [31:0] o,
                       input logic [4:0] s, input logic [1:0] nc, input logic [2:0] np,
                       input logic urb, input int poke_at, input int rb_at, output int lat);
    @(negedge clk);
    clr_tok++;
    @(negedge clk);
    phase_kind = k; cmd_byte = c; byte_ofs = o; cfg_page_shift = s;
    cfg_col_cycles = nc; cfg_page_cycles = np; cfg_use_rb = urb;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 3000) begin
      @(negedge clk);
      lat++;
      if (lat == poke_at) begin
        start = 1'b1; phase_kind = 2'd3; cmd_byte = 8'hAA;
      end else begin
        start = 1'b0;
      end
      if (lat == rb_at) rb_ready = 1'b1;
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not finish actual=0 expected=1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    int lat;
    int expl;
    rst_n = 1'b0; start = 1'b0; phase_kind = 2'd0; cmd_byte = 8'h00;
    byte_ofs = '0; cfg_page_shift = 5'd9; cfg_col_cycles = 2'd1;
    cfg_page_cycles = 3'd3; cfg_use_rb = 1'b0; rb_ready = 1'b0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(we_n && re_n && !cle && !ale && !dq_oe && !busy && !done && !timeout_err,
        "R12 reset idle", {we_n, re_n, cle, ale, dq_oe, busy, done, timeout_err}, 8'hC0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // vector table walk
    for (int i = 0; i < 8; i++) begin
      mon_nb = int'(VECS[i].nb);
      mon_addr = (VECS[i].kind != 2'd0);
      issue(VECS[i].kind, VECS[i].cmd, VECS[i].ofs, VECS[i].sh, VECS[i].nc, VECS[i].np,
            1'b0, -1, -1, lat);
      expl = 2 + int'(VECS[i].nb) * STB + ((VECS[i].kind == 2'd0) ? TB_CW : TB_AW);
      chk(lat == expl, "R8 done latency", lat, expl);
      chk(cap_n == int'(VECS[i].nb), "R5 byte count", cap_n, VECS[i].nb);
      for (int b = 0; b < int'(VECS[i].nb); b++) begin
        chk(cap_dq[b] == {8'h00, VECS[i].exp[b*8 +: 8]}, "R3 R4 R6 byte value",
            cap_dq[b], {8'h00, VECS[i].exp[b*8 +: 8]});
        if (VECS[i].kind == 2'd0)
          chk(cap_cle[b] && !cap_ale[b], "R1 cle during command", {cap_cle[b], cap_ale[b]}, 2'b10);
        else
          chk(cap_ale[b] && !cap_cle[b], "R2 ale during address", {cap_cle[b], cap_ale[b]}, 2'b01);
        chk(cap_lo[b] == LO, "R7 we low width", cap_lo[b], LO);
      end
      if (VECS[i].nb > 1) begin
        chk(gap_last == HI, "R7 we high width", gap_last, HI);
        chk(ale_gap == 0, "R2 ale held between bytes", ale_gap, 0);
      end
      chk(!cle && !ale, "R1 R2 latch low at done", {cle, ale}, 2'b00);
    end
    mon_addr = 1'b0;

    // R11: start while busy ignored
    issue(2'd0, 8'h30, 32'h0, 5'd9, 2'd1, 3'd1, 1'b0, 3, -1, lat);
    chk(lat == 2 + STB + TB_CW, "R11 timing unchanged by start while busy", lat, 2 + STB + TB_CW);
    chk(cap_n == 1 && cap_dq[0] == 16'h0030, "R11 bytes unchanged by start while busy", cap_dq[0], 16'h0030);
    @(negedge clk);
    chk(!done, "R11 done single cycle", done, 0);
    repeat (10) @(negedge clk);
    chk(!busy && cap_n == 1, "R11 no second request", {busy, 8'(cap_n)}, 9'd1);

    // R9: reset command without ready pin polls status
    issue(2'd0, 8'hFF, 32'h0, 5'd9, 2'd1, 3'd1, 1'b0, -1, -1, lat);
    expl = 2 + STB + TB_CW + STB + 3 * STB;
    chk(lat == expl, "R9 polling latency", lat, expl);
    chk(cap_n == 2, "R9 two command bytes", cap_n, 2);
    chk(cap_dq[1] == 16'h0070 && cap_cle[1], "R9 status command", cap_dq[1], 16'h0070);
    chk(rd_cnt == 3, "R9 read strobes", rd_cnt, 3);
    chk(oe_bad == 0, "R6 no drive during read", oe_bad, 0);

    // R9 / R10: reset command with ready pin high: no polling
    rb_ready = 1'b1;
    issue(2'd0, 8'hFF, 32'h0, 5'd9, 2'd1, 3'd1, 1'b1, -1, -1, lat);
    chk(lat == 2 + STB + 1, "R10 ready already high", lat, 2 + STB + 1);
    chk(rd_cnt == 0 && cap_n == 1, "R9 no poll with ready pin", rd_cnt, 0);

    // R10: timeout
    rb_ready = 1'b0;
    issue(2'd1, 8'h00, 32'h0000_0055, 5'd8, 2'd1, 3'd1, 1'b1, -1, -1, lat);
    chk(lat == 2 + STB + TB_TO, "R10 timeout latency", lat, 2 + STB + TB_TO);
    chk(timeout_err, "R10 timeout flag", timeout_err, 1);
    repeat (3) @(negedge clk);
    chk(timeout_err, "R10 flag holds while idle", timeout_err, 1);

    // R10: ready raised at a known cycle, flag cleared by new start
    issue(2'd1, 8'h00, 32'h0000_0055, 5'd8, 2'd1, 3'd1, 1'b1, -1, 20, lat);
    chk(lat == 21, "R10 done after ready", lat, 21);
    chk(!timeout_err, "R10 flag cleared by start", timeout_err, 0);
    rb_ready = 1'b0;

    // R12: reset in the middle of an address phase
    @(negedge clk);
    phase_kind = 2'd3; byte_ofs = 32'h89AB_CDEF; cfg_page_shift = 5'd8;
    cfg_col_cycles = 2'd1; cfg_page_cycles = 3'd4; cfg_use_rb = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(we_n && !ale && !busy && !dq_oe, "R12 reset mid phase", {we_n, ale, busy, dq_oe}, 4'b1000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && we_n, "R12 idle after release", {busy, we_n}, 2'b01);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule